// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block is the digital control core of a single-channel 16-bit voltage DAC. Commands arrive as 24-bit frames on a mode-0 SPI slave port (active-low select, serial clock, data in, most significant bit first). The select, clock and data pins are oversampled by the system clock through synchronizers. The block keeps two register stages, a preload register and an active register. A frame that ends with exactly the expected number of clocks is decoded and applied when chip select rises. Any other frame is dropped.

A mode bit chooses where a plain write lands. When the bit is clear, the write goes through to the active register. When it is set, the write only fills the preload register, and the data reaches the output later through the hardware load pin or a software load command. A level-sensitive clear pin and a software clear both use a clear value of zero or midscale, chosen by a strap pin. A power-down command turns the output amplifier off and leaves the output either floating or pulled to ground. Commands are still accepted and stored during power-down.

The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. Every pin is a plain control or level signal. Serial bits are captured on each rising serial clock while select is low. The output code is a level that always shows the current register state.

Top module: `dac_reg_ctrl`

## Requirements
- R1: A frame is decoded at the rising edge of `spi_cs_n` only when exactly 24 rising `spi_sclk` edges were seen while it was low. A frame with 23, 25 or any other count changes nothing.
- R2: During reset and after it, `dac_code` is 16'h8000 when `mid_sel`=1 and 16'h0000 when `mid_sel`=0. After reset the mode bit is 0, `amp_en`=1, and `out_hiz`=`out_gnd`=0.
- R3: Opcode 1 (write) with the mode bit at 0 puts data bits [15:0] on `dac_code`. With the mode bit at 1 it loads only the preload register, and `dac_code` keeps its value.
- R4: Opcode 2 (write and update) and opcode 3 (write all) load the active register from data bits [15:0], whatever the mode bit holds.
- R5: Opcode 4 (software load) copies the preload register into the active register.
- R6: While `load_n` is low, the preload register is copied into the active register.
- R7: While `clear_n` is low, `dac_code` shows the clear value (16'h8000 when `mid_sel`=1, 16'h0000 otherwise) and follows `mid_sel`. When `clear_n` goes high again, the active register's code returns unchanged.
- R8: Opcode 5 (software clear) sets the active register to the clear value chosen by `mid_sel`.
- R9: Opcode 6 (power-down) sets power-down from data bit 0 and the pulldown choice from data bit 1 (1 = ground, 0 = high impedance). In power-down `amp_en`=0 and exactly one of `out_hiz`/`out_gnd` is 1. Out of power-down `amp_en`=1 and both are 0.
- R10: Commands that arrive during power-down are applied to the registers, and the stored code appears on `dac_code` in power-down and after it ends.
- R11: Opcode 7 sets the mode bit from data bit 0. Opcodes 0 and 8 to 15 change nothing.
- R12: Frame layout: bits [23:20] hold the opcode and bits [15:0] hold the data. Bits [19:16] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | SPI serial data in, MSB first |
| load_n | input | 1 | Hardware load, active low, level |
| clear_n | input | 1 | Hardware clear, active low, level |
| mid_sel | input | 1 | Clear value select: 1 = midscale, 0 = zero |
| dac_code | output | 16 | Code sent to the converter |
| amp_en | output | 1 | Output amplifier enable |
| out_hiz | output | 1 | Output is high impedance (power-down) |
| out_gnd | output | 1 | Output is pulled to ground (power-down) |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, a 24-bit frame and two synchronizer stages. With a 24-bit frame, frames of 23 and 25 clocks are short enough to send, so both sides of the exact-length rule are checked. The 16-bit width fixes the midscale code at 16'h8000, which the bench compares against on reset, the clear pin and the clear command. The bench also reaches the write-block mode, power-down with each pulldown choice, and a mid_sel change while the clear pin is held low.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_WR    = 4'd1,
    OP_WRUP  = 4'd2,
    OP_WRALL = 4'd3,
    OP_LOAD  = 4'd4,
    OP_CLR   = 4'd5,
    OP_PWR   = 4'd6,
    OP_MODE  = 4'd7
  } op_e;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          STAGES = 2,
  parameter int          W      = 1,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_ctrl_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  output logic              frame_valid,
  output logic [OPC_W-1:0]  frame_op,
  output logic [DATA_W-1:0] frame_data
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic               cs_d, sclk_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_d        <= 1'b1;
      sclk_d      <= 1'b0;
      cnt         <= '0;
      shreg       <= '0;
      frame_valid <= 1'b0;
    end else begin
      cs_d        <= cs_n_s;
      sclk_d      <= sclk_s;
      frame_valid <= 1'b0;
      if (cs_d && !cs_n_s) begin
        cnt <= '0;
      end else if (!cs_n_s && sclk_s && !sclk_d) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
      if (!cs_d && cs_n_s) frame_valid <= (cnt == CNT_W'(FRAME_W));
    end
  end

  assign frame_op   = shreg[FRAME_W-1 -: OPC_W];
  assign frame_data = shreg[DATA_W-1:0];

  assert_frame_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  assert_count_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [OPC_W-1:0]  frame_op,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              load_n_s,
  input  logic              clear_n_s,
  input  logic              mid_sel,
  output logic [DATA_W-1:0] dac_code,
  output logic              amp_en,
  output logic              out_hiz,
  output logic              out_gnd
);
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] pre_q, act_q, pre_n, act_n, clr_val;
  logic              wb_q, pd_q, gnd_q, wb_n, pd_n, gnd_n;
  op_e               op;

  assign op      = op_e'(frame_op);
  assign clr_val = mid_sel ? MID_CODE : '0;

  always_comb begin
    pre_n = pre_q;
    act_n = act_q;
    wb_n  = wb_q;
    pd_n  = pd_q;
    gnd_n = gnd_q;
    if (!load_n_s) act_n = pre_q;
    if (frame_valid) begin
      case (op)
        OP_WR:            if (wb_q) pre_n = frame_data; else act_n = frame_data;
        OP_WRUP, OP_WRALL: act_n = frame_data;
        OP_LOAD:          act_n = pre_q;
        OP_CLR:           act_n = clr_val;
        OP_PWR: begin
          pd_n  = frame_data[0];
          gnd_n = frame_data[1];
        end
        OP_MODE:          wb_n = frame_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= clr_val;
      act_q <= clr_val;
      wb_q  <= 1'b0;
      pd_q  <= 1'b0;
      gnd_q <= 1'b0;
    end else begin
      pre_q <= pre_n;
      act_q <= act_n;
      wb_q  <= wb_n;
      pd_q  <= pd_n;
      gnd_q <= gnd_n;
    end
  end

  assign dac_code = clear_n_s ? act_q : clr_val;
  assign amp_en   = !pd_q;
  assign out_hiz  = pd_q & !gnd_q;
  assign out_gnd  = pd_q & gnd_q;

  assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid && load_n_s) |=> $stable(act_q));
  assert_write_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && op == OP_WR && wb_q && load_n_s) |=> $stable(act_q));
  assert_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && (op == OP_WRUP || op == OP_WRALL)) |=> act_q == $past(frame_data));
  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && op == OP_CLR) |=> act_q == ($past(mid_sel) ? MID_CODE : '0));
  assert_pd_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && op == OP_PWR) |=> amp_en == !$past(frame_data[0]));
  assert_out_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({amp_en, out_hiz, out_gnd}) == 1);
endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FRAME_W     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic              mid_sel,
  output logic [DATA_W-1:0] dac_code,
  output logic              amp_en,
  output logic              out_hiz,
  output logic              out_gnd
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] PIN_IDLE = 5'b10011;

  logic [NPIN-1:0]   pins_s;
  logic              fv;
  logic [OPC_W-1:0]  f_op;
  logic [DATA_W-1:0] f_data;

  dac_sync #(.STAGES(SYNC_STAGES), .W(NPIN), .INIT(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi, load_n, clear_n}),
    .q     (pins_s)
  );

  dac_frame_rx #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_s      (pins_s[4]),
    .sclk_s      (pins_s[3]),
    .mosi_s      (pins_s[2]),
    .frame_valid (fv),
    .frame_op    (f_op),
    .frame_data  (f_data)
  );

  dac_reg_bank #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (fv),
    .frame_op    (f_op),
    .frame_data  (f_data),
    .load_n_s    (pins_s[1]),
    .clear_n_s   (pins_s[0]),
    .mid_sel     (mid_sel),
    .dac_code    (dac_code),
    .amp_en      (amp_en),
    .out_hiz     (out_hiz),
    .out_gnd     (out_gnd)
  );
endmodule

// File: tb/dac_reg_ctrl_test.sv
module dac_reg_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic load_n = 1'b1, clear_n = 1'b1, mid_sel = 1'b1;
  logic [15:0] dac_code;
  logic amp_en, out_hiz, out_gnd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] code;
    logic        amp, hiz, gnd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  dac_reg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .load_n(load_n), .clear_n(clear_n), .mid_sel(mid_sel),
    .dac_code(dac_code), .amp_en(amp_en), .out_hiz(out_hiz), .out_gnd(out_gnd)
  );

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    spi_cs_n = 1'b0;
    clocks(4);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = w[i];
      clocks(3);
      spi_sclk = 1'b1;
      clocks(3);
      spi_sclk = 1'b0;
    end
    clocks(3);
    spi_cs_n = 1'b1;
    clocks(12);
  endtask

  task automatic cmd(input logic [3:0] op, input logic [15:0] d);
    send_bits({8'h00, op, 4'h0, d}, 24);
  endtask

  task automatic expect_out(input logic [15:0] c, input logic a, input logic h,
                            input logic g, input string tag);
    exp_t e;
    e.code = c; e.amp = a; e.hiz = h; e.gnd = g; e.tag = tag;
    sb.push_back(e);
    wait (sb.size() == 0);
    clocks(1);
  endtask

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() != 0);
      @(negedge clk);
      e = sb[0];
      checks++;
      if (dac_code !== e.code || amp_en !== e.amp || out_hiz !== e.hiz || out_gnd !== e.gnd) begin
        failures++;
        $display("FAIL %s: code=%h amp=%b hiz=%b gnd=%b expected code=%h amp=%b hiz=%b gnd=%b",
                 e.tag, dac_code, amp_en, out_hiz, out_gnd, e.code, e.amp, e.hiz, e.gnd);
      end
      void'(sb.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clocks(5);
    expect_out(16'h8000, 1, 0, 0, "R2 reset midscale");
    rst_n = 1'b1;
    clocks(4);
    expect_out(16'h8000, 1, 0, 0, "R2 after reset");

    cmd(4'd1, 16'h1234);
    expect_out(16'h1234, 1, 0, 0, "R3 write-through");
    cmd(4'd7, 16'h0001);
    cmd(4'd1, 16'h5555);
    expect_out(16'h1234, 1, 0, 0, "R3 R11 write-block holds output");
    cmd(4'd4, 16'h0000);
    expect_out(16'h5555, 1, 0, 0, "R5 software load");

    cmd(4'd1, 16'h0AAA);
    expect_out(16'h5555, 1, 0, 0, "R3 preload only");
    load_n = 1'b0; clocks(6); load_n = 1'b1; clocks(6);
    expect_out(16'h0AAA, 1, 0, 0, "R6 hardware load");

    cmd(4'd2, 16'h2222);
    expect_out(16'h2222, 1, 0, 0, "R4 write-and-update");
    cmd(4'd3, 16'h3333);
    expect_out(16'h3333, 1, 0, 0, "R4 write-all");

    send_bits({8'h00, 4'd2, 4'h0, 16'h7777} >> 1, 23);
    expect_out(16'h3333, 1, 0, 0, "R1 23-clock frame dropped");
    send_bits({7'h00, 1'b1, 4'd2, 4'h0, 16'h7777}, 25);
    expect_out(16'h3333, 1, 0, 0, "R1 25-clock frame dropped");

    send_bits({8'h00, 4'd2, 4'hF, 16'h4444}, 24);
    expect_out(16'h4444, 1, 0, 0, "R12 bits 19:16 ignored");
    cmd(4'd9, 16'h1111);
    cmd(4'd0, 16'h1111);
    cmd(4'd15, 16'h1111);
    expect_out(16'h4444, 1, 0, 0, "R11 unknown opcodes ignored");

    clear_n = 1'b0; clocks(6);
    expect_out(16'h8000, 1, 0, 0, "R7 clear pin midscale");
    mid_sel = 1'b0; clocks(2);
    expect_out(16'h0000, 1, 0, 0, "R7 clear pin zero");
    clear_n = 1'b1; clocks(6);
    expect_out(16'h4444, 1, 0, 0, "R7 clear release restores code");

    cmd(4'd5, 16'h0000);
    expect_out(16'h0000, 1, 0, 0, "R8 software clear zero");
    mid_sel = 1'b1;
    cmd(4'd2, 16'h1357);
    cmd(4'd5, 16'h0000);
    expect_out(16'h8000, 1, 0, 0, "R8 software clear midscale");

    cmd(4'd6, 16'h0003);
    expect_out(16'h8000, 0, 0, 1, "R9 power-down ground");
    cmd(4'd2, 16'h6666);
    expect_out(16'h6666, 0, 0, 1, "R10 write during power-down");
    cmd(4'd6, 16'h0001);
    expect_out(16'h6666, 0, 1, 0, "R9 power-down high impedance");
    cmd(4'd6, 16'h0000);
    expect_out(16'h6666, 1, 0, 0, "R9 R10 exit power-down");

    cmd(4'd7, 16'h0000);
    cmd(4'd1, 16'h0F0F);
    expect_out(16'h0F0F, 1, 0, 0, "R11 R3 mode back to write-through");

    rst_n = 1'b0; mid_sel = 1'b0; clocks(3);
    rst_n = 1'b1; clocks(3);
    expect_out(16'h0000, 1, 0, 0, "R2 reset zero");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule